// File: doc/BRIEF.md
# Pulse-Qualified Carrier Detector

This block decides whether a valid FSK carrier is present on a receive line. It works from a digital pulse stream: an analog comparator outside the block emits one pulse for each received cycle whose amplitude clears a threshold. The block counts the rising edges of that stream. It raises its carrier-present flag only after a run of consecutive edges has arrived, each one close enough to the one before it.

Once raised, the flag is held for as long as every new edge follows the previous one within a timeout window. The default window is 2.5 ms, which is 1152 cycles of the 460.8 kHz time base. If the stream falls silent for longer than that, the flag drops, and a fresh run must build up before it can rise again.

The transmit request input is active low. While it is low, the local modem is sending. During that time the flag is forced low and all qualification state is cleared, so the modem never reports its own outgoing signal as a carrier.

Top module: `carrier_sense`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `carrier_o` is 0. No carrier is reported until a full run of edges has been seen.
- R2: `carrier_o` goes to 1 on the clock edge that registers the RUN_LEN-th (default 4) consecutive qualifying rising edge. With the default two-stage synchroniser, a `pulse_in` rise first sampled at clock edge n makes `carrier_o` high after clock edge n+2. Fewer edges never set it.
- R3: Once `carrier_o` is high, it stays high as long as the spacing between successive sampled rises of `pulse_in` is at most GAP_CYCLES (default 1152) clock cycles. The boundary spacing of exactly GAP_CYCLES still holds the flag.
- R4: If no rise arrives for more than GAP_CYCLES cycles after the last registered edge, `carrier_o` goes to 0. A rise sampled at edge n with nothing after it drops the flag after edge n+GAP_CYCLES+3. An edge that arrives after the timeout counts as the first of a new run.
- R5: While `rts_n` is 0, `carrier_o` is 0 in the same cycle. The output is gated directly by `rts_n`.
- R6: While `rts_n` is 0, the run count is cleared and the gap timer is held expired. Pulses during that time are not counted. After `rts_n` returns to 1, RUN_LEN new edges are needed before the flag rises.
- R7: Each `pulse_in` pulse counts once, on its rising edge, however long it stays high.
- R8: Pulse trains at the 1200 Hz spacing (384 cycles) and at the 2200 Hz spacing (about 209 cycles) both qualify.
- R9: While a run is still building up, a gap longer than GAP_CYCLES discards the partial count. Edges with spacing GAP_CYCLES+1 never raise the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 460.8 kHz time base |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rts_n | input | 1 | Transmit request, active low; low suppresses and clears detection |
| pulse_in | input | 1 | Comparator pulse stream, asynchronous to `clk` |
| carrier_o | output | 1 | High while a qualified carrier is present |

## Verification
A rise of `pulse_in` that is first sampled at clock edge n reaches the run counter at edge n+2. That is the edge on which `carrier_o` may rise, and it is also the edge from which the gap timer counts. The timeout drop therefore lands GAP_CYCLES+1 edges after that. `rts_n` acts on the output in the same cycle and on the state at the next edge. The bench keeps a per-cycle expectation that models the two-edge lag as a delay line of observed input rises. It compares `carrier_o` one nanosecond after every falling clock edge, after all flops and input changes have settled. Directed checks sample at least three edges after a rise, or one nanosecond after an `rts_n` change.

// File: rtl/carrier_sense_pkg.sv
package carrier_sense_pkg;
  // 2.5 ms at 460.8 kHz
  localparam int unsigned GAP_CYCLES_DEF = 1152;
  localparam int unsigned RUN_LEN_DEF    = 4;
  localparam int unsigned SYNC_DEF       = 2;
endpackage

// File: rtl/cs_edge_sync.sv
module cs_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= raw_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R7
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cs_gap_timer.sv
module cs_gap_timer #(
  parameter int unsigned GAP_CYCLES = 1152
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic rise_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(GAP_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(GAP_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (clr_i)              cnt_d = LIMIT;
    else if (rise_i)        cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    else                    cnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= LIMIT;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == LIMIT);

  // R3
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  // R6
  gap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> expired_o);
endmodule

// File: rtl/cs_run_counter.sv
module cs_run_counter #(
  parameter int unsigned RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic rise_i,
  input  logic expired_i,
  output logic full_o
);
  localparam int unsigned RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] TOP = RW'(RUN_LEN);

  logic [RW-1:0] run_q, run_d;
  logic          run_en;

  always_comb begin
    run_en = 1'b1;
    run_d  = run_q;
    if (clr_i)             run_d = '0;
    else if (rise_i) begin
      if (expired_i)       run_d = RW'(1);
      else if (run_q != TOP) run_d = run_q + 1'b1;
      else                 run_en = 1'b0;
    end
    else if (expired_i)    run_d = '0;
    else                   run_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  assign full_o = (run_q == TOP);

  // R2
  full_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_o) |-> $past(rise_i));
  // R9
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= TOP);
endmodule

// File: rtl/carrier_sense.sv
module carrier_sense
  import carrier_sense_pkg::*;
#(
  parameter int unsigned GAP_CYCLES  = GAP_CYCLES_DEF,
  parameter int unsigned RUN_LEN     = RUN_LEN_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rts_n,
  input  logic pulse_in,
  output logic carrier_o
);
  logic rise;
  logic expired;
  logic full;
  logic tx_active;

  assign tx_active = ~rts_n;

  cs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pulse_in),
    .rise_o (rise)
  );

  cs_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (tx_active),
    .rise_i    (rise),
    .expired_o (expired)
  );

  cs_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (tx_active),
    .rise_i    (rise),
    .expired_i (expired),
    .full_o    (full)
  );

  assign carrier_o = full & rts_n;

  // R4
  timeout_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !rise) |=> !full);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rise && !expired && rts_n) |=> full);
  // R6
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_n |=> !full);
  // R5
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts_n) |-> !carrier_o);
endmodule

// File: tb/test_carrier_sense.sv
`timescale 1ns/1ps
module test_carrier_sense;
  localparam int GAP = 1152;
  localparam int RUN = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic rts_n;
  logic pulse_in;
  logic carrier_o;

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  carrier_sense i_carrier_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .rts_n     (rts_n),
    .pulse_in  (pulse_in),
    .carrier_o (carrier_o)
  );

  // Expectation: input rise observed at edge n acts at edge n+2
  int   m_run;
  int   m_gap;
  logic m_prev;
  logic [1:0] m_hist;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_gap = GAP; m_prev = 1'b0; m_hist = 2'b00;
    end else begin
      logic eff;
      eff    = m_hist[1];
      m_hist = {m_hist[0], pulse_in & ~m_prev};
      m_prev = pulse_in;
      if (!rts_n) begin
        m_run = 0; m_gap = GAP;
      end else if (eff) begin
        m_run = (m_gap < GAP) ? ((m_run < RUN) ? m_run + 1 : RUN) : 1;
        m_gap = 0;
      end else if (m_gap >= GAP) begin
        m_run = 0;
      end else begin
        m_gap = m_gap + 1;
      end
    end
  end

  function automatic logic exp_carrier(int run, logic rts);
    return (run == RUN) && rts;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: carrier_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) check(phase, carrier_o, exp_carrier(m_run, rts_n));
  end

  task automatic pulse(int period, int width);
    @(negedge clk); pulse_in = 1'b1;
    repeat (width) @(negedge clk);
    pulse_in = 1'b0;
    repeat (period - width - 1) @(negedge clk);
  endtask

  task automatic train(int count, int period, int width);
    for (int i = 0; i < count; i++) pulse(period, width);
  endtask

  task automatic idle(int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    #760000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; rts_n = 1'b1; pulse_in = 1'b0;
    repeat (3) @(negedge clk);
    #1 check("R1", carrier_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk); #1 check("R1", carrier_o, 1'b0);

    // R8 / R2: 1200 Hz tone, three pulses are not enough
    phase = "R2";
    train(3, 384, 192);
    #1 check("R2", carrier_o, 1'b0);
    train(1, 384, 192);
    #1 check("R8", carrier_o, 1'b1);

    // R3: spacing exactly at the limit holds the flag
    phase = "R3";
    train(3, GAP, 300);
    #1 check("R3", carrier_o, 1'b1);

    // R4: silence beyond the window drops the flag
    phase = "R4";
    idle(200);
    #1 check("R4", carrier_o, 1'b0);

    // R9: spacing one past the limit never qualifies
    phase = "R9";
    train(6, GAP + 1, 100);
    #1 check("R9", carrier_o, 1'b0);
    idle(GAP);
    train(2, 209, 100);
    idle(GAP + 50);
    train(3, 209, 100);
    #1 check("R9", carrier_o, 1'b0);
    train(1, 209, 100);
    #1 check("R9", carrier_o, 1'b1);

    // R8: 2200 Hz tone after a full timeout
    phase = "R8";
    idle(GAP + 20);
    train(4, 209, 104);
    #1 check("R8", carrier_o, 1'b1);

    // R5 / R6: transmit request suppresses and clears
    phase = "R5";
    @(negedge clk); rts_n = 1'b0;
    #1 check("R5", carrier_o, 1'b0);
    phase = "R6";
    train(5, 209, 100);
    #1 check("R6", carrier_o, 1'b0);
    rts_n = 1'b1;
    train(3, 209, 100);
    #1 check("R6", carrier_o, 1'b0);
    train(1, 209, 100);
    #1 check("R6", carrier_o, 1'b1);

    // R7: long pulses count once each
    phase = "R7";
    idle(GAP + 20);
    train(3, 1100, 1090);
    #1 check("R7", carrier_o, 1'b0);
    train(1, 1100, 1090);
    #1 check("R7", carrier_o, 1'b1);

    // random mix, all requirements against the per-cycle model
    phase = "R3";
    for (int i = 0; i < 90; i++) begin
      int per;
      int wid;
      per = $urandom_range(1400, 60);
      wid = $urandom_range(per - 2, 1);
      if ($urandom_range(9, 0) == 0) rts_n = ~rts_n;
      pulse(per, wid);
    end
    rts_n = 1'b1;
    idle(GAP + 10);
    #1 check("R4", carrier_o, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule